// File: doc/BRIEF.md
# Frame Descriptor Ring Capture DMA Controller

This block is the control engine of a frame-capture DMA. It holds a ring of frame descriptors in a small internal memory. Software fills this memory through a simple word-wide write/read port. The engine visits the ring entries in order and handles one frame per entry. Ownership of an entry passes from software to hardware through a per-entry VALID flag, which software writes last. When the engine finds an entry without that flag, it stops and reports itself halted. For every frame it works out how many 4 KB pages the target buffer spans and the inclusive offset of the last usable byte in the final page. It then issues page-bounded write requests as (page index, offset in page, length) triples.

A frame is bracketed by a start pulse and an end pulse. The end pulse carries the number of bytes the sensor side delivered. When the frame completes, the engine stores that count back into the descriptor and clears VALID, which returns the entry to software. It then advances its ring pointer, and it can raise a start interrupt and a completion interrupt, each requested by its own descriptor bit. Interrupt status is write-one-to-clear and is masked onto a single interrupt line. The current ring pointer and the halted state are always visible on status outputs.

Each descriptor uses four words, addressed as `{entry, word}`:
- word 0 holds the control bits: bit 0 VALID, bit 1 start-interrupt request, bit 2 completion-interrupt request.
- word 1 holds the first-page byte offset in bits [11:0].
- word 2 holds the buffer length in bytes in bits [23:0].
- word 3 receives the byte count written back by the engine.

Top module: `fdring_dma`

## Requirements
- R1: After a synchronous reset, `halted` is 1, `stat_rp` is 0, `irq` and `irq_sts` are 0, and no request is issued.
- R2: A rising edge of `en` while halted makes the engine leave the halted state and read entry `stat_rp`. If that entry's VALID bit (word 0 bit 0) is set, the engine waits for a frame start.
- R3: If the engine reads an entry whose VALID bit is clear, it halts with `stat_rp` unchanged. It stays halted while `en` remains high and resumes only after `en` goes low and then high again.
- R4: A frame start (`sof`) accepted while the engine waits on a valid entry sets `irq_sts` bit 0 when word 0 bit 1 of that entry is set.
- R5: On frame completion, the engine writes the received count (`eof_bytes`) into word 3 and rewrites word 0 with bit 0 cleared and the other bits kept. It sets `irq_sts` bit 1 when word 0 bit 2 is set, and only then.
- R6: `stat_rp` advances by one after each completed frame and wraps from 31 to 0.
- R7: Write requests start at page 0 at the first-page offset and run through consecutive pages. Each later request starts at offset 0. No request is empty, and none crosses a 4096-byte page boundary.
- R8: The buffer spans ceil((offset + length) / 4096) pages. The final page is usable up to an inclusive last-byte offset (0 means one byte, 4095 means the whole page). Received bytes beyond that point are discarded, and a zero-length buffer produces no requests, while the full received count is still written back.
- R9: `irq_sts` bits are cleared by writing 1 to the matching `irq_clr` bit, and a set in the same cycle wins. `irq` equals the OR of `irq_sts` masked by `irq_en`.
- R10: Lowering `en` halts the engine only at a safe point: while it is fetching or waiting for a frame start, the entry is left untouched. A frame already started runs to completion and write-back before the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable; a rising edge restarts a halted engine |
| sw_we | input | 1 | Descriptor memory write strobe |
| sw_addr | input | 7 | Descriptor word address {entry, word} |
| sw_wdata | input | 32 | Descriptor write data |
| sw_rdata | output | 32 | Registered read data of `sw_addr` |
| sof | input | 1 | Frame start pulse |
| eof | input | 1 | Frame end pulse |
| eof_bytes | input | 24 | Bytes received in the frame, valid with `eof` |
| req_v | output | 1 | Write request valid |
| req_page | output | 13 | Page index within the buffer |
| req_off | output | 12 | Byte offset inside the page |
| req_len | output | 13 | Request length in bytes (1..4096) |
| irq_en | input | 2 | Interrupt mask (bit 0 start, bit 1 completion) |
| irq_clr | input | 2 | Write-one-to-clear strobes for `irq_sts` |
| irq_sts | output | 2 | Interrupt status (bit 0 start, bit 1 completion) |
| irq | output | 1 | Masked interrupt line |
| stat_rp | output | 5 | Current ring pointer |
| halted | output | 1 | Engine halted |

## Verification
The bound checker watches on every cycle that each request stays within one page and is never empty. It also checks that no request goes past the computed last page, that the halted state persists until a fresh enable edge, and that the ring pointer only ever steps by one with wrap. The interrupt line must always match the masked status, and a clear strobe must remove a status bit unless a set arrives with it. Only the bench scenarios can show the page splitting of concrete buffers and the discard of bytes beyond the last-page limit. The same holds for the counts and control words written back, the choice between interrupting and not interrupting per descriptor, the safe-point behaviour of a disable mid-frame, and the ring wrap after 32 frames.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [3:0] {
    S_HALT, S_RD0, S_RD1, S_RD2, S_RD3, S_WSOF, S_WEOF, S_BURST, S_WB0, S_WB1
  } eng_state_e;

  // word select inside one descriptor
  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_OFF  = 2'd1;
  localparam logic [1:0] W_LEN  = 2'd2;
  localparam logic [1:0] W_CNT  = 2'd3;

  // control word bits
  localparam int B_VALID = 0;
  localparam int B_IOS   = 1;
  localparam int B_IOC   = 2;
endpackage

// File: rtl/fdr_desc_ram.sv
module fdr_desc_ram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // engine port wins a same-word collision
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we && !(b_we && (b_addr == a_addr))) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/fdr_burst.sv
module fdr_burst #(
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [PAGE_W-1:0]   first_off,
  input  logic [LEN_W-1:0]    nbytes,
  input  logic [LEN_W-PAGE_W:0] last_pg,
  input  logic [PAGE_W-1:0]   last_lim,
  output logic                req_v,
  output logic [LEN_W-PAGE_W:0] req_page,
  output logic [PAGE_W-1:0]   req_off,
  output logic [PAGE_W:0]     req_len,
  output logic                done
);
  localparam int PG_W = LEN_W - PAGE_W + 1;
  localparam int CH_W = PAGE_W + 1;

  logic            busy;
  logic [PG_W-1:0] pg_q;
  logic [PAGE_W-1:0] po_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CH_W-1:0] top, avail, chunk;
  logic            on_last;

  always_comb begin
    on_last = (pg_q == last_pg);
    top     = on_last ? ({1'b0, last_lim} + CH_W'(1)) : CH_W'(1 << PAGE_W);
    avail   = top - {1'b0, po_q};
    chunk   = (rem_q < LEN_W'(avail)) ? rem_q[CH_W-1:0] : avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; req_v <= 1'b0; done <= 1'b0;
      pg_q <= '0; po_q <= '0; rem_q <= '0;
      req_page <= '0; req_off <= '0; req_len <= '0;
    end else if (start) begin
      busy  <= (nbytes != '0);
      done  <= (nbytes == '0);
      pg_q  <= '0;
      po_q  <= first_off;
      rem_q <= nbytes;
      req_v <= 1'b0;
    end else if (busy) begin
      req_v    <= 1'b1;
      req_page <= pg_q;
      req_off  <= po_q;
      req_len  <= chunk;
      rem_q    <= rem_q - LEN_W'(chunk);
      pg_q     <= pg_q + PG_W'(1);
      po_q     <= '0;
      if ((rem_q == LEN_W'(chunk)) || on_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end else begin
      req_v <= 1'b0;
      done  <= 1'b0;
    end
  end
endmodule

// File: rtl/fdr_irq.sv
module fdr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] nxt;
  always_comb nxt = (sts & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= nxt;
      irq <= |(nxt & en);
    end
  end
endmodule

// File: rtl/fdring_dma.sv
module fdring_dma
  import fdr_pkg::*;
#(
  parameter int RING   = 32,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      sw_we,
  input  logic [$clog2(RING)+1:0]   sw_addr,
  input  logic [DATA_W-1:0]         sw_wdata,
  output logic [DATA_W-1:0]         sw_rdata,
  input  logic                      sof,
  input  logic                      eof,
  input  logic [LEN_W-1:0]          eof_bytes,
  output logic                      req_v,
  output logic [LEN_W-PAGE_W:0]     req_page,
  output logic [PAGE_W-1:0]         req_off,
  output logic [PAGE_W:0]           req_len,
  input  logic [1:0]                irq_en,
  input  logic [1:0]                irq_clr,
  output logic [1:0]                irq_sts,
  output logic                      irq,
  output logic [$clog2(RING)-1:0]   stat_rp,
  output logic                      halted
);
  localparam int RP_W = $clog2(RING);
  localparam int MA_W = RP_W + 2;
  localparam int PG_W = LEN_W - PAGE_W + 1;

  eng_state_e state, nstate;
  logic [RP_W-1:0]   rp;
  logic              en_q, halted_q;
  logic [DATA_W-1:0] w0_q, w0_ret;
  logic [PAGE_W-1:0] off_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              eng_we;
  logic [MA_W-1:0]   eng_addr;
  logic [DATA_W-1:0] eng_wd, eng_q;
  logic [LEN_W:0]    sum;
  logic [PG_W-1:0]   pages, last_pg;
  logic [PAGE_W-1:0] last_lim;
  logic              bg_start, bg_done;
  logic [1:0]        irq_set;

  // buffer geometry: page count and inclusive last-byte offset
  always_comb begin
    sum      = {1'b0, len_q} + (LEN_W+1)'(off_q);
    pages    = sum[LEN_W:PAGE_W] + PG_W'(|sum[PAGE_W-1:0]);
    last_pg  = pages - PG_W'(1);
    last_lim = (|sum[PAGE_W-1:0]) ? (sum[PAGE_W-1:0] - PAGE_W'(1)) : '1;
  end

  always_comb begin
    w0_ret          = w0_q;
    w0_ret[B_VALID] = 1'b0;
  end

  always_comb begin
    nstate   = state;
    eng_we   = 1'b0;
    eng_addr = {rp, W_CTRL};
    eng_wd   = '0;
    bg_start = 1'b0;
    irq_set  = 2'b00;
    case (state)
      S_HALT:  if (en && !en_q) nstate = S_RD0;
      S_RD0:   begin
        eng_addr = {rp, W_CTRL};
        nstate   = en ? S_RD1 : S_HALT;
      end
      S_RD1:   begin
        eng_addr = {rp, W_OFF};
        nstate   = eng_q[B_VALID] ? S_RD2 : S_HALT;
      end
      S_RD2:   begin
        eng_addr = {rp, W_LEN};
        nstate   = S_RD3;
      end
      S_RD3:   nstate = S_WSOF;
      S_WSOF:  if (!en) nstate = S_HALT;
               else if (sof) begin
                 irq_set[0] = w0_q[B_IOS];
                 nstate     = S_WEOF;
               end
      S_WEOF:  if (eof) begin
                 bg_start = 1'b1;
                 nstate   = S_BURST;
               end
      S_BURST: if (bg_done) nstate = S_WB0;
      S_WB0:   begin
        eng_we   = 1'b1;
        eng_addr = {rp, W_CNT};
        eng_wd   = DATA_W'(cnt_q);
        nstate   = S_WB1;
      end
      S_WB1:   begin
        eng_we     = 1'b1;
        eng_addr   = {rp, W_CTRL};
        eng_wd     = w0_ret;
        irq_set[1] = w0_q[B_IOC];
        nstate     = S_RD0;
      end
      default: nstate = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_HALT;
      halted_q <= 1'b1;
      en_q     <= 1'b0;
      rp       <= '0;
      w0_q     <= '0;
      off_q    <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
    end else begin
      state    <= nstate;
      halted_q <= (nstate == S_HALT);
      en_q     <= en;
      if (state == S_RD1) w0_q  <= eng_q;
      if (state == S_RD2) off_q <= eng_q[PAGE_W-1:0];
      if (state == S_RD3) len_q <= eng_q[LEN_W-1:0];
      if (bg_start)       cnt_q <= eof_bytes;
      if (state == S_WB1) rp <= (rp == RP_W'(RING-1)) ? '0 : rp + RP_W'(1);
    end
  end

  assign stat_rp = rp;
  assign halted  = halted_q;

  fdr_desc_ram #(.AW(MA_W), .DW(DATA_W)) u_ram (
    .clk(clk),
    .a_we(sw_we), .a_addr(sw_addr), .a_wdata(sw_wdata), .a_rdata(sw_rdata),
    .b_we(eng_we), .b_addr(eng_addr), .b_wdata(eng_wd), .b_rdata(eng_q)
  );

  fdr_burst #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst(rst), .start(bg_start),
    .first_off(off_q),
    .nbytes((len_q == '0) ? '0 : eof_bytes),
    .last_pg(last_pg), .last_lim(last_lim),
    .req_v(req_v), .req_page(req_page), .req_off(req_off), .req_len(req_len),
    .done(bg_done)
  );

  fdr_irq #(.N(2)) u_irq (
    .clk(clk), .rst(rst), .set(irq_set), .clr(irq_clr), .en(irq_en),
    .sts(irq_sts), .irq(irq)
  );
endmodule

// File: rtl/fdr_checker.sv
module fdr_checker #(
  parameter int RING   = 32,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    req_v,
  input logic [LEN_W-PAGE_W:0]   req_page,
  input logic [PAGE_W-1:0]       req_off,
  input logic [PAGE_W:0]         req_len,
  input logic [LEN_W-PAGE_W:0]   last_pg,
  input logic                    halted,
  input logic [$clog2(RING)-1:0] stat_rp,
  input logic                    irq,
  input logic [1:0]              irq_sts,
  input logic [1:0]              irq_en,
  input logic [1:0]              irq_clr,
  input logic [1:0]              irq_set
);
  localparam int RP_W = $clog2(RING);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (halted && stat_rp == '0 && !irq && irq_sts == 2'b00 && !req_v));

  a_r7_req_in_page: assert property (@(posedge clk) disable iff (rst)
    req_v |-> (req_len != '0 && ({1'b0, req_off} + req_len) <= (PAGE_W+1)'(1 << PAGE_W)));

  a_r8_req_last_page: assert property (@(posedge clk) disable iff (rst)
    req_v |-> (req_page <= last_pg));

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halted && !$rose(en)) |=> halted);

  a_r3_no_req_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !req_v);

  a_r6_rp_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_rp) |->
      (stat_rp == (($past(stat_rp) == RP_W'(RING-1)) ? '0 : $past(stat_rp) + RP_W'(1))));

  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    ((irq_clr & ~irq_set) != 2'b00) |=> ((irq_sts & $past(irq_clr & ~irq_set)) == 2'b00));

  a_r9_irq_mask: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_sts & $past(irq_en)));
endmodule

bind fdring_dma fdr_checker #(.RING(RING), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .req_v(req_v), .req_page(req_page),
  .req_off(req_off), .req_len(req_len), .last_pg(last_pg), .halted(halted),
  .stat_rp(stat_rp), .irq(irq), .irq_sts(irq_sts), .irq_en(irq_en),
  .irq_clr(irq_clr), .irq_set(irq_set)
);

// File: tb/tb_fdring_dma.sv
module tb_fdring_dma;
  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, sw_we = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [6:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic [23:0] eof_bytes = '0;
  logic        req_v, irq, halted;
  logic [12:0] req_page, req_len;
  logic [11:0] req_off;
  logic [1:0]  irq_en = 2'b00, irq_clr = 2'b00, irq_sts;
  logic [4:0]  stat_rp;

  int nchk = 0, nfail = 0;
  logic [37:0] expq[$];
  logic [37:0] got_r, exp_r;
  logic [31:0] rd;

  always #10 clk = ~clk;

  fdring_dma dut (
    .clk(clk), .rst(rst), .en(en), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .sof(sof), .eof(eof),
    .eof_bytes(eof_bytes), .req_v(req_v), .req_page(req_page), .req_off(req_off),
    .req_len(req_len), .irq_en(irq_en), .irq_clr(irq_clr), .irq_sts(irq_sts),
    .irq(irq), .stat_rp(stat_rp), .halted(halted)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sw_write(input int idx, input int w, input logic [31:0] d);
    @(posedge clk); #1;
    sw_we = 1'b1; sw_addr = {5'(idx), 2'(w)}; sw_wdata = d;
    @(posedge clk); #1;
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input int idx, input int w, output logic [31:0] d);
    @(posedge clk); #1;
    sw_addr = {5'(idx), 2'(w)};
    tick(1);
    d = sw_rdata;
  endtask

  task automatic desc(input int idx, input int ctrl, input int off, input int len);
    sw_write(idx, 1, 32'(off));
    sw_write(idx, 2, 32'(len));
    sw_write(idx, 0, 32'(ctrl)); // VALID written last
  endtask

  // driver side of the scoreboard: expected requests from the rules
  task automatic push_exp(input int off, input int len, input int n);
    int rem;
    int pos;
    rem = (len == 0) ? 0 : ((n < len) ? n : len);
    pos = off;
    while (rem > 0) begin
      int po;
      int c;
      po = pos % 4096;
      c  = 4096 - po;
      if (c > rem) c = rem;
      expq.push_back({13'(pos / 4096), 12'(po), 13'(c)});
      pos += c;
      rem -= c;
    end
  endtask

  task automatic pulse_sof();
    @(posedge clk); #1; sof = 1'b1;
    @(posedge clk); #1; sof = 1'b0;
  endtask

  task automatic pulse_eof(input int n);
    @(posedge clk); #1; eof = 1'b1; eof_bytes = 24'(n);
    @(posedge clk); #1; eof = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    @(posedge clk); #1; irq_clr = m;
    @(posedge clk); #1; irq_clr = 2'b00;
  endtask

  task automatic wait_rp(input int exp, input string tag);
    int k;
    k = 0;
    while (stat_rp != 5'(exp) && k < 400) begin
      tick(1);
      k++;
    end
    chk(stat_rp == 5'(exp), tag, stat_rp, exp);
  endtask

  task automatic run_frame(input int off, input int len, input int n);
    push_exp(off, len, n);
    tick(6);
    pulse_sof();
    tick(2);
    pulse_eof(n);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && req_v) begin
      got_r = {req_page, req_off, req_len};
      if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected request", got_r, 0);
      end else begin
        exp_r = expq.pop_front();
        chk(got_r == exp_r, "R7/R8 request {page,off,len}", got_r, exp_r);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(halted == 1'b1, "R1 halted", halted, 1);
    chk(stat_rp == 5'd0, "R1 stat_rp", stat_rp, 0);
    chk(irq == 1'b0 && irq_sts == 2'b00, "R1 irq", {irq, irq_sts}, 0);
    chk(req_v == 1'b0, "R1 req_v", req_v, 0);

    for (int i = 0; i < 32; i++) sw_write(i, 0, 32'd0);
    desc(0, 7, 100, 10000);
    desc(1, 1, 0, 4096);
    desc(2, 5, 4000, 50);
    desc(3, 1, 4090, 10);

    irq_en = 2'b11;
    en = 1'b1;
    tick(8);
    chk(halted == 1'b0, "R2 running after enable", halted, 0);

    // entry 0: three pages, start and completion interrupts
    push_exp(100, 10000, 10000);
    pulse_sof();
    chk(irq_sts[0] == 1'b1, "R4 start status", irq_sts, 1);
    chk(irq == 1'b1, "R9 irq from start", irq, 1);
    pulse_clr(2'b01);
    chk(irq_sts == 2'b00, "R9 W1C start bit", irq_sts, 0);
    chk(irq == 1'b0, "R9 irq dropped", irq, 0);
    pulse_eof(10000);
    wait_rp(1, "R6 rp after entry 0");
    chk(irq_sts[1] == 1'b1, "R5 completion status", irq_sts, 2);
    sw_read(0, 3, rd);
    chk(rd == 32'd10000, "R5 count written back", rd, 10000);
    sw_read(0, 0, rd);
    chk(rd == 32'd6, "R5 VALID cleared others kept", rd, 6);
    pulse_clr(2'b11);
    chk(irq_sts == 2'b00 && irq == 1'b0, "R9 clear all", {irq, irq_sts}, 0);

    // entry 1: full single page, excess received bytes discarded
    run_frame(0, 4096, 6000);
    wait_rp(2, "R6 rp after entry 1");
    sw_read(1, 3, rd);
    chk(rd == 32'd6000, "R8 received count kept", rd, 6000);
    chk(irq_sts == 2'b00, "R5 no interrupt without request", irq_sts, 0);

    // entry 2: completion only, masked
    irq_en = 2'b00;
    run_frame(4000, 50, 30);
    wait_rp(3, "R6 rp after entry 2");
    chk(irq_sts == 2'b10, "R5 completion only", irq_sts, 2);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    irq_en = 2'b10;
    tick(1);
    chk(irq == 1'b1, "R9 unmasked", irq, 1);
    pulse_clr(2'b11);
    irq_en = 2'b11;

    // entry 3: straddles a page, last-byte offset 3
    run_frame(4090, 10, 10);
    wait_rp(4, "R6 rp after entry 3");

    // entry 4 invalid: halt
    tick(6);
    chk(halted == 1'b1, "R3 halted on invalid", halted, 1);
    chk(stat_rp == 5'd4, "R3 rp held", stat_rp, 4);
    tick(10);
    chk(halted == 1'b1, "R3 stays halted with en high", halted, 1);

    desc(4, 1, 0, 0);
    for (int i = 5; i < 32; i++) desc(i, 1, 0, 16);
    desc(0, 3, 0, 100);
    en = 1'b0; tick(2); en = 1'b1;
    tick(8);
    chk(halted == 1'b0, "R3 resumes after new enable edge", halted, 0);

    // R10: disable while waiting for frame start
    en = 1'b0;
    tick(4);
    chk(halted == 1'b1, "R10 halted at safe point", halted, 1);
    chk(stat_rp == 5'd4, "R10 rp held", stat_rp, 4);
    sw_read(4, 0, rd);
    chk(rd == 32'd1, "R10 entry untouched", rd, 1);
    en = 1'b1;
    tick(2);

    // entry 4: zero-length buffer
    run_frame(0, 0, 100);
    wait_rp(5, "R6 rp after entry 4");
    sw_read(4, 3, rd);
    chk(rd == 32'd100, "R8 zero-length buffer count", rd, 100);

    // entry 5: disable mid-frame
    push_exp(0, 16, 16);
    tick(6);
    pulse_sof();
    en = 1'b0;
    tick(2);
    pulse_eof(16);
    wait_rp(6, "R10 frame completes after disable");
    tick(8);
    chk(halted == 1'b1, "R10 halted after frame", halted, 1);
    sw_read(5, 3, rd);
    chk(rd == 32'd16, "R10 write-back done", rd, 16);
    en = 1'b1;
    tick(2);

    for (int i = 6; i < 32; i++) begin
      run_frame(0, 16, 16);
      wait_rp((i + 1) % 32, "R6 ring advance");
    end
    chk(stat_rp == 5'd0, "R6 wrap 31 to 0", stat_rp, 0);

    // entry 0 again after wrap
    push_exp(0, 100, 100);
    tick(6);
    pulse_sof();
    chk(irq_sts[0] == 1'b1, "R4 start after wrap", irq_sts, 1);
    tick(2);
    pulse_eof(100);
    wait_rp(1, "R6 rp after wrap frame");
    sw_read(0, 0, rd);
    chk(rd == 32'd2, "R5 VALID cleared after wrap", rd, 2);
    tick(6);
    chk(halted == 1'b1, "R3 halt on returned entry", halted, 1);
    chk(expq.size() == 0, "R7 all requests seen", expq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule